// File: doc/BRIEF.md
# Multiplexed LCD Segment Waveform Sequencer

This block produces the drive levels for a three-common, one-third-duty LCD panel with up to 25 segment lines. It works from a 75-bit display image. Every output is a 2-bit level code, and an external resistor or buffer network turns that code into a voltage. The block only decides which rail each line sits on at each moment. The clock input is the display base clock. One frame lasts 384 base-clock periods and is split into three equal common slots. The drive polarity flips on every frame so the panel sees no net DC.

Control inputs set the following:
- one-half or one-third bias,
- a segments-off mode,
- a sleep mode,
- how many of the first four segment pins work as plain logic outputs,
- how many of the last two segment pins stay segments rather than being handed to an external key-scan circuit.

A new display image is captured only on a load strobe. A frame therefore never shows a half-written image.

Top module: `lcd_seg_seq`

## Requirements
- R1: After reset, `slot_o` is 0 and `frame_pol_o` is 0. `slot_o` steps 0→1→2→0, advancing once every 128 clocks. `frame_pol_o` toggles when `slot_o` wraps from 2 to 0, giving a 384-clock frame.
- R2: Level codes are 0 = ground, 1 = one third, 2 = two thirds, 3 = full supply. Common c drives `com_o[2c+1:2c]`.
  - The common whose index equals `slot_o` drives 3 when `frame_pol_o`=0 and drives 0 when `frame_pol_o`=1.
  - With `bias_half_i`=0, the other commons drive 1 (polarity 0) or 2 (polarity 1).
  - With `bias_half_i`=1, the other commons drive 1 in both polarities.
- R3: Segment pin k (0-based, `seg_o[2k+1:2k]`) shows latched bit 3k+`slot_o`. When that bit is 1, the pin drives 0 at polarity 0 and 3 at polarity 1.
- R4: When that bit is 0, the pin drives the off level.
  - With `bias_half_i`=0, the off level is 2 at polarity 0 and 1 at polarity 1.
  - With `bias_half_i`=1, the off level is 1.
- R5: With `seg_off_i`=1, every pin in segment function drives the off level of R4, whatever the latched data.
- R6: The display latch takes `data_i` only at a rising clock edge with `load_i`=1. At all other times `data_i` has no effect on the outputs.
- R7: Let n = min(`port_sel_i`, 4). Pins 0..n-1 are logic outputs. Such a pin drives 3 if latched bit 3k is 1 and 0 otherwise, whatever the slot, polarity, bias or `seg_off_i`.
- R8: Pins in logic-output function keep their R7 value while `sleep_i`=1.
- R9: With `sleep_i`=1, all commons and all pins in segment function drive 0. At each clock edge with `sleep_i`=1, the slot, the polarity and the 128-clock count all return to 0.
- R10: `key_sel_i` selects the scan lines, and a pin given to scan drives 0 on `seg_o`.
  - `key_sel_i`=00 gives `scan_sel_o`=11.
  - `key_sel_i`=01 gives `scan_sel_o`=10.
  - `key_sel_i`=1x gives `scan_sel_o`=00.
  - Bit 0 of `scan_sel_o` is pin 23 and bit 1 is pin 24.
- R11: While `rst_ni` is low, every `com_o`/`seg_o` code is 0 and `scan_sel_o` is 00, whatever `port_sel_i` and `key_sel_i` say. Pins 0-3 are held as segments, and the latch clears to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Display base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture `data_i` into the display latch |
| data_i | input | 75 | Display image, bit 3k+c for pin k, common c |
| bias_half_i | input | 1 | 1: one-half bias, 0: one-third bias |
| seg_off_i | input | 1 | Force off waveform on all segment pins |
| sleep_i | input | 1 | Blank display and hold frame timer |
| port_sel_i | input | 3 | Count of leading pins used as logic outputs |
| key_sel_i | input | 2 | Count of trailing pins kept as segments |
| slot_o | output | 2 | Current common slot |
| frame_pol_o | output | 1 | Current frame polarity |
| com_o | output | 6 | Common level codes, 2 bits each |
| seg_o | output | 50 | Segment pin level codes, 2 bits each |
| scan_sel_o | output | 2 | Pins 23/24 handed to key scan |

## Verification
The hardest situation to reach from the ports combines three things: a logic-output pin held through sleep, a frame-polarity flip, and a latch update that lands in the middle of a frame. All three must happen while the data bus keeps moving. The stimulus sweeps every `port_sel_i` code with sleep toggled between steps. It then runs several thousand cycles in which `data_i` changes every clock, loads fire at random about once in forty cycles, and the control inputs are reshuffled every few dozen cycles. A directed step changes `data_i` without a load and checks that the segment levels still follow the earlier image.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int NCOM = 3;

  typedef enum logic [1:0] {
    LV_GND   = 2'd0,
    LV_THIRD = 2'd1,
    LV_TWO3  = 2'd2,
    LV_FULL  = 2'd3
  } lvl_e;

  // selected common sits on a rail, others on a mid level
  function automatic lvl_e com_lvl(logic half, logic pol, logic sel);
    if (sel)       return pol ? LV_GND : LV_FULL;
    else if (half) return LV_THIRD;
    else           return pol ? LV_TWO3 : LV_THIRD;
  endfunction

  // on: opposite rail to the selected common; off: mid level
  function automatic lvl_e seg_lvl(logic half, logic pol, logic on);
    if (on)        return pol ? LV_FULL : LV_GND;
    else if (half) return LV_THIRD;
    else           return pol ? LV_THIRD : LV_TWO3;
  endfunction
endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int SLOT_TICKS = 128,
  localparam int CW = $clog2(SLOT_TICKS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  output logic [1:0] slot_o,
  output logic       pol_o
);
  logic [CW-1:0] cnt_q;
  logic [1:0]    slot_q;
  logic          pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slot_q <= '0;
      pol_q  <= 1'b0;
    end else if (hold_i) begin
      cnt_q  <= '0;
      slot_q <= '0;
      pol_q  <= 1'b0;
    end else if (cnt_q == CW'(SLOT_TICKS - 1)) begin
      cnt_q <= '0;
      if (slot_q == 2'd2) begin
        slot_q <= '0;
        pol_q  <= ~pol_q;
      end else begin
        slot_q <= slot_q + 2'd1;
      end
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign slot_o = slot_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/lcd_disp_latch.sv
module lcd_disp_latch #(
  parameter int DW = 75
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
  import lcd_seq_pkg::*;
(
  input  logic              blank_i,
  input  logic              half_i,
  input  logic              pol_i,
  input  logic [1:0]        slot_i,
  output logic [2*NCOM-1:0] com_o
);
  for (genvar c = 0; c < NCOM; c++) begin : g_com
    lvl_e lv;
    always_comb lv = blank_i ? LV_GND : com_lvl(half_i, pol_i, slot_i == 2'(c));
    assign com_o[2*c +: 2] = lv;
  end
endmodule

// File: rtl/lcd_pin_mux.sv
module lcd_pin_mux
  import lcd_seq_pkg::*;
#(
  parameter int NSEG  = 25,
  parameter int NGPIO = 4,
  parameter int NSCAN = 2,
  localparam int DW  = NCOM * NSEG,
  localparam int PSW = $clog2(NGPIO + 1),
  localparam int KSW = $clog2(NSCAN + 1),
  localparam int SB  = NSEG - NSCAN
) (
  input  logic [DW-1:0]     disp_i,
  input  logic [1:0]        slot_i,
  input  logic              pol_i,
  input  logic              half_i,
  input  logic              seg_off_i,
  input  logic              blank_i,
  input  logic [PSW-1:0]    gpio_cnt_i,
  input  logic [KSW-1:0]    keep_cnt_i,
  output logic [2*NSEG-1:0] seg_o,
  output logic [NSCAN-1:0]  scan_sel_o
);
  for (genvar k = 0; k < NSEG; k++) begin : g_pin
    logic [NCOM-1:0] trip;
    logic            gp, sc;
    lvl_e            lv;
    assign trip = disp_i[NCOM*k +: NCOM];

    if (k < NGPIO) begin : g_gp
      assign gp = PSW'(k) < gpio_cnt_i;
    end else begin : g_nogp
      assign gp = 1'b0;
    end

    if (k >= SB) begin : g_sc
      assign sc = !(KSW'(k - SB) < keep_cnt_i);
      assign scan_sel_o[k - SB] = sc;
    end else begin : g_nosc
      assign sc = 1'b0;
    end

    always_comb begin
      if (gp)                lv = trip[0] ? LV_FULL : LV_GND;
      else if (sc || blank_i) lv = LV_GND;
      else                   lv = seg_lvl(half_i, pol_i, trip[slot_i] & ~seg_off_i);
    end
    assign seg_o[2*k +: 2] = lv;
  end
endmodule

// File: rtl/lcd_seg_seq.sv
module lcd_seg_seq
  import lcd_seq_pkg::*;
#(
  parameter int FRAME_TICKS = 384,
  parameter int NSEG  = 25,
  parameter int NGPIO = 4,
  parameter int NSCAN = 2,
  localparam int DW  = NCOM * NSEG,
  localparam int PSW = $clog2(NGPIO + 1),
  localparam int KSW = $clog2(NSCAN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DW-1:0]     data_i,
  input  logic              bias_half_i,
  input  logic              seg_off_i,
  input  logic              sleep_i,
  input  logic [PSW-1:0]    port_sel_i,
  input  logic [KSW-1:0]    key_sel_i,
  output logic [1:0]        slot_o,
  output logic              frame_pol_o,
  output logic [2*NCOM-1:0] com_o,
  output logic [2*NSEG-1:0] seg_o,
  output logic [NSCAN-1:0]  scan_sel_o
);
  localparam int SLOT_TICKS = FRAME_TICKS / NCOM;

  logic [DW-1:0]  disp;
  logic           blank;
  logic [PSW-1:0] gpio_cnt;
  logic [KSW-1:0] keep_cnt;

  assign blank = sleep_i | ~rst_ni;

  // saturate codes; reset forces all pins to segment function
  always_comb begin
    if (!rst_ni)                          gpio_cnt = '0;
    else if (port_sel_i > PSW'(NGPIO))    gpio_cnt = PSW'(NGPIO);
    else                                  gpio_cnt = port_sel_i;
    if (!rst_ni || key_sel_i > KSW'(NSCAN)) keep_cnt = KSW'(NSCAN);
    else                                    keep_cnt = key_sel_i;
  end

  lcd_frame_timer #(.SLOT_TICKS(SLOT_TICKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (sleep_i),
    .slot_o (slot_o),
    .pol_o  (frame_pol_o)
  );

  lcd_disp_latch #(.DW(DW)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .d_i    (data_i),
    .q_o    (disp)
  );

  lcd_com_drv u_com (
    .blank_i (blank),
    .half_i  (bias_half_i),
    .pol_i   (frame_pol_o),
    .slot_i  (slot_o),
    .com_o   (com_o)
  );

  lcd_pin_mux #(.NSEG(NSEG), .NGPIO(NGPIO), .NSCAN(NSCAN)) u_mux (
    .disp_i     (disp),
    .slot_i     (slot_o),
    .pol_i      (frame_pol_o),
    .half_i     (bias_half_i),
    .seg_off_i  (seg_off_i),
    .blank_i    (blank),
    .gpio_cnt_i (gpio_cnt),
    .keep_cnt_i (keep_cnt),
    .seg_o      (seg_o),
    .scan_sel_o (scan_sel_o)
  );
endmodule

// File: rtl/lcd_seg_seq_chk.sv
module lcd_seg_seq_chk #(
  parameter int PSW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sleep_i,
  input logic [PSW-1:0] port_sel_i,
  input logic [1:0]     slot_o,
  input logic           frame_pol_o,
  input logic [5:0]     com_o,
  input logic [1:0]     seg_first_i,
  input logic [1:0]     seg_scan_i,
  input logic           scan_first_i
);
  logic [2:0] rail;
  for (genvar c = 0; c < 3; c++) begin : g_rail
    assign rail[c] = (com_o[2*c +: 2] == 2'd0) || (com_o[2*c +: 2] == 2'd3);
  end

  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(sleep_i) && slot_o != $past(slot_o)) |->
      slot_o == (($past(slot_o) == 2'd2) ? 2'd0 : $past(slot_o) + 2'd1)); // R1
  AST_POL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(sleep_i) && frame_pol_o != $past(frame_pol_o)) |->
      ($past(slot_o) == 2'd2 && slot_o == 2'd0)); // R1
  AST_COM_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> com_o[2*slot_o +: 2] == (frame_pol_o ? 2'd0 : 2'd3)); // R2
  AST_COM_ONE_RAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> $countones(rail) == 1); // R2
  AST_GPIO_RAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_sel_i != '0 |-> (seg_first_i == 2'd0 || seg_first_i == 2'd3)); // R7
  AST_SLEEP_COM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> com_o == 6'd0); // R9
  AST_SLEEP_TIMER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (slot_o == 2'd0 && !frame_pol_o)); // R9
  AST_SCAN_PIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_first_i |-> seg_scan_i == 2'd0); // R10
endmodule

bind lcd_seg_seq lcd_seg_seq_chk #(.PSW(PSW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sleep_i      (sleep_i),
  .port_sel_i   (port_sel_i),
  .slot_o       (slot_o),
  .frame_pol_o  (frame_pol_o),
  .com_o        (com_o),
  .seg_first_i  (seg_o[1:0]),
  .seg_scan_i   (seg_o[2*(NSEG-NSCAN) +: 2]),
  .scan_first_i (scan_sel_o[0])
);

// File: tb/lcd_seg_seq_bench.sv
module lcd_seg_seq_bench;
  localparam int NSEG = 25;
  localparam int DW   = 75;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load;
  logic [DW-1:0] data;
  logic          bias_half, seg_off, sleep;
  logic [2:0]    port_sel;
  logic [1:0]    key_sel;
  logic [1:0]    slot;
  logic          pol;
  logic [5:0]    com;
  logic [2*NSEG-1:0] seg;
  logic [1:0]    scan_sel;

  int nvec = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcd_seg_seq u_lcd_seg_seq (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .data_i(data),
    .bias_half_i(bias_half), .seg_off_i(seg_off), .sleep_i(sleep),
    .port_sel_i(port_sel), .key_sel_i(key_sel), .slot_o(slot),
    .frame_pol_o(pol), .com_o(com), .seg_o(seg), .scan_sel_o(scan_sel)
  );

  // reference model of timer and latch, from R1, R6, R9, R11
  int            mcnt, mslot;
  bit            mpol;
  logic [DW-1:0] mdata;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt <= 0; mslot <= 0; mpol <= 0; mdata <= '0;
    end else begin
      if (load) mdata <= data;
      if (sleep) begin
        mcnt <= 0; mslot <= 0; mpol <= 0;
      end else if (mcnt == 127) begin
        mcnt  <= 0;
        mslot <= (mslot + 1) % 3;
        if (mslot == 2) mpol <= ~mpol;
      end else mcnt <= mcnt + 1;
    end
  end

  function automatic int gcount();
    return (port_sel > 3'd4) ? 4 : int'(port_sel);
  endfunction

  function automatic bit is_scan(int k);
    return (k == 23 && key_sel == 2'd0) || (k == 24 && key_sel < 2'd2);
  endfunction

  function automatic logic [1:0] exp_com(int c);
    if (!rst_n || sleep) return 2'd0;
    if (c == mslot) return mpol ? 2'd0 : 2'd3;
    if (bias_half) return 2'd1;
    return mpol ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [1:0] exp_seg(int k);
    bit onb;
    if (!rst_n) return 2'd0;
    if (k < gcount()) return mdata[3*k] ? 2'd3 : 2'd0;
    if (is_scan(k) || sleep) return 2'd0;
    onb = !seg_off && mdata[3*k + mslot];
    if (onb) return mpol ? 2'd3 : 2'd0;
    if (bias_half) return 2'd1;
    return mpol ? 2'd1 : 2'd2;
  endfunction

  function automatic string seg_tag(int k);
    if (!rst_n) return "R11";
    if (k < gcount()) return sleep ? "R8" : "R7";
    if (is_scan(k)) return "R10";
    if (sleep) return "R9";
    if (seg_off) return "R5";
    return mdata[3*k + mslot] ? "R3" : "R4";
  endfunction

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string req, input string what);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string rq;
    rq = !rst_n ? "R11" : "R1";
    chk(slot, 2'(mslot), rq, "slot");
    chk({1'b0, pol}, {1'b0, mpol}, rq, "polarity");
    for (int c = 0; c < 3; c++)
      chk(com[2*c +: 2], exp_com(c), (!rst_n ? "R11" : (sleep ? "R9" : "R2")), $sformatf("com%0d", c));
    for (int k = 0; k < NSEG; k++)
      chk(seg[2*k +: 2], exp_seg(k), seg_tag(k), $sformatf("seg%0d", k));
    chk(scan_sel, !rst_n ? 2'b00 : (key_sel == 2'd0 ? 2'b11 : (key_sel == 2'd1 ? 2'b10 : 2'b00)),
        !rst_n ? "R11" : "R10", "scan_sel");
  endtask

  task automatic cyc();
    @(negedge clk);
    check_all();
  endtask

  function automatic logic [DW-1:0] rnd_data();
    logic [95:0] t;
    t = {$urandom, $urandom, $urandom};
    return t[DW-1:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] pat;
    void'($urandom(32'd7135));
    rst_n = 1'b0; load = 1'b1; data = {25{3'b101}};
    bias_half = 1'b0; seg_off = 1'b0; sleep = 1'b0;
    port_sel = 3'd4; key_sel = 2'd0;
    // R11: reset forces all low, latch stays clear despite load
    repeat (4) cyc();
    @(negedge clk); rst_n = 1'b1; load = 1'b0;
    port_sel = 3'd0; key_sel = 2'd2;
    // R1..R4 under one-third bias, two full frames
    data = {25{3'b110}} ^ 75'h5A5A5A5A5A5A5A5A5A5; load = 1'b1;
    cyc(); load = 1'b0;
    repeat (800) cyc();
    bias_half = 1'b1;                      // R2, R4 half bias
    repeat (400) cyc();
    bias_half = 1'b0; seg_off = 1'b1;      // R5
    repeat (150) cyc();
    seg_off = 1'b0;
    // R6: data bus moves without load; outputs keep old image
    pat = rnd_data(); data = pat; load = 1'b1;
    cyc(); load = 1'b0; data = ~pat;
    repeat (20) cyc();
    chk(seg[9:8], (pat[12 + mslot] ? (mpol ? 2'd3 : 2'd0) : (mpol ? 2'd1 : 2'd2)), "R6", "seg4 held image");
    // R7, R8: port codes with sleep toggled
    for (int p = 0; p < 8; p++) begin
      port_sel = 3'(p); sleep = p[0];
      data = rnd_data(); load = 1'b1; cyc(); load = 1'b0;
      repeat (60) cyc();
    end
    sleep = 1'b0;
    // R10: every scan code
    for (int s = 0; s < 4; s++) begin
      key_sel = 2'(s);
      repeat (60) cyc();
    end
    // R9: sleep then wake restarts the frame
    repeat (200) cyc();
    sleep = 1'b1; repeat (50) cyc();
    sleep = 1'b0; repeat (400) cyc();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 64 == 0) begin
        bias_half = 1'($urandom); seg_off = ($urandom % 4 == 0);
        sleep = ($urandom % 5 == 0); port_sel = 3'($urandom);
        key_sel = 2'($urandom);
      end
      load = ($urandom % 40 == 0);
      data = rnd_data();
      cyc();
    end
    // R11: asynchronous reset mid-run
    load = 1'b0; sleep = 1'b0; port_sel = 3'd3; key_sel = 2'd0;
    rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (300) cyc();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule